// File: doc/BRIEF.md
# Presettable Divide-by-N Down Counter

This block is a 4-bit down counter for frequency division. Each count event lowers the value by one. A parameter picks the modulus. In decade mode the count wraps from 0 to 9, and in binary mode it wraps from 0 to 15. A load input copies a 4-bit preset word into the count and takes precedence over counting. A clear input forces the count to zero and takes precedence over both. There are two ways to produce a count event: a rising edge of the count clock while the hold input is low, or a falling edge of the hold input while the count clock is high. The second path lets the hold input act as a falling-edge clock.

The zero flag is high when three things are true at once: the count is 0, the chain-enable input is high, and clear is inactive. For a single stage, route the zero flag back into the load input. The stage then reloads its preset word every N count events and divides by N. In a chain of stages, the chain-enable input lets the zero flag depend on the stages next to it.

The count clock, hold, clear and load inputs all come from outside the system clock domain. Each is passed through a two-flop synchronizer on the system clock. Edges are found by comparing each synchronized sample with the one taken one cycle earlier.

Top module: `divn_down_counter`

## Requirements
- R1: While `rst_n` is low, the count is 0. After `rst_n` is released, the count stays 0 until a count event, load or clear occurs.
- R2: Hold is low when the count clock rises. The count then drops by exactly one, three system-clock edges after the input rises. A falling count clock has no effect.
- R3: While hold is high, rising edges of the count clock leave the count unchanged.
- R4: The count drops by one when hold falls while the count clock is high. A hold fall while the count clock is low leaves the count unchanged.
- R5: While load is high and clear is low, the count equals `preset_i`, and count-clock edges do not change it.
- R6: Clear high forces the count to 0. Clear wins over load and over counting.
- R7: `zero_o` is high only when the count is 0, `chain_fb_i` is high, and clear is low. With `chain_fb_i` low, or with clear high, `zero_o` is low.
- R8: A count event at 0 gives 9 when DECADE=1 and 15 when DECADE=0.
- R9: In decade mode, preset values 10 to 15 load exactly as given and then count down by one per event (for example, 12 becomes 11).
- R10: With `zero_o` wired to load, `chain_fb_i` high and a preset of N, `zero_o` rises once every N count events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cnt_clk_i | input | 1 | Count clock; its rising edge is a count event while hold is low |
| hold_i | input | 1 | Blocks the count clock when high; its falling edge is a count event while the count clock is high |
| clear_i | input | 1 | Forces the count to zero; highest priority |
| load_i | input | 1 | Loads `preset_i` into the count |
| preset_i | input | 4 | Preset word |
| chain_fb_i | input | 1 | Enables the zero flag |
| count_o | output | 4 | Current count |
| zero_o | output | 1 | Zero flag |

## Verification
Each external control passes through two synchronizer flops. The edge detector then compares this sample with the previous one, so the count register updates on the third system-clock edge after an input changes. `zero_o` follows clear two edges after a change and follows the count with no extra delay. The bench changes inputs just after a falling edge of the system clock. Each input level is held for four or more cycles, and the bench waits at least four more cycles before it samples at a falling edge. Every check therefore reads a value that has settled. The divide-by-N check counts rising edges of `zero_o` over a fixed number of spaced count pulses.

// File: rtl/divn_down_counter.sv
module divn_down_counter #(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_clk_i,
  input  logic             hold_i,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] preset_i,
  input  logic             chain_fb_i,
  output logic [WIDTH-1:0] count_o,
  output logic             zero_o
);
  localparam int NSIG = 4;
  localparam logic [WIDTH-1:0] WRAP = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  logic [NSIG-1:0] meta_q, sync_q, prev_q;
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= {load_i, clear_i, hold_i, cnt_clk_i};
      sync_q <= meta_q;
      prev_q <= sync_q;
    end

  wire ck_s  = sync_q[0];
  wire hd_s  = sync_q[1];
  wire clr_s = sync_q[2];
  wire ld_s  = sync_q[3];

  wire ck_rise = ck_s & ~prev_q[0];
  wire hd_fall = ~hd_s & prev_q[1];
  wire step    = (ck_rise & ~hd_s) | (hd_fall & ck_s);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                cnt_q <= '0;
    else if (clr_s)            cnt_q <= '0;
    else if (ld_s)             cnt_q <= preset_i;
    else if (step)             cnt_q <= (cnt_q == '0) ? WRAP : cnt_q - 1'b1;

  assign count_o = cnt_q;
  assign zero_o  = ~clr_s & chain_fb_i & (cnt_q == '0);

  a_r6_clear_forces_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> (cnt_q == '0));

  a_r5_load_takes_preset: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_s && !clr_s) |=> (cnt_q == $past(preset_i)));

  a_r3_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (hd_s && !clr_s && !ld_s) |=> $stable(cnt_q));

  a_r2_down_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && !ld_s) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1
                           || ($past(cnt_q) == '0 && cnt_q == WRAP)));

  a_r7_zero_needs_count0: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o |-> (count_o == '0 && chain_fb_i));
endmodule

// File: tb/divn_down_counter_tb_top.sv
module divn_down_counter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_clk = 1'b0, hold = 1'b0, clear = 1'b0, load_drv = 1'b0, cf = 1'b1;
  logic fb_mode = 1'b0;
  logic [3:0] preset = 4'd0;
  logic [3:0] cnt_d, cnt_b;
  logic zero_d, zero_b, load_d;
  int checks = 0, errors = 0;
  int zero_rises = 0;
  logic zero_prev = 1'b0;
  logic count_rises = 1'b0;

  always #5 clk = ~clk;

  assign load_d = fb_mode ? zero_d : load_drv;

  divn_down_counter #(.WIDTH(4), .DECADE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_clk_i(cnt_clk), .hold_i(hold), .clear_i(clear),
    .load_i(load_d), .preset_i(preset), .chain_fb_i(cf), .count_o(cnt_d), .zero_o(zero_d));

  divn_down_counter #(.WIDTH(4), .DECADE(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .cnt_clk_i(cnt_clk), .hold_i(hold), .clear_i(clear),
    .load_i(load_drv), .preset_i(preset), .chain_fb_i(cf), .count_o(cnt_b), .zero_o(zero_b));

  always @(negedge clk) begin
    if (count_rises && zero_d && !zero_prev) zero_rises++;
    zero_prev <= zero_d;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse();
    cnt_clk = 1'b1; wait_cyc(5);
    cnt_clk = 1'b0; wait_cyc(5);
  endtask

  task automatic do_load(input logic [3:0] v);
    preset = v; load_drv = 1'b1; wait_cyc(5);
    load_drv = 1'b0; wait_cyc(5);
  endtask

  task automatic t_reset();
    wait_cyc(3); rst_n = 1'b1; wait_cyc(6);
    chk("R1 count after reset", cnt_d, 0);
    chk("R1 zero flag after reset", zero_d, 1);
  endtask

  task automatic t_wrap();
    pulse();
    chk("R8 decade wrap", cnt_d, 9);
    chk("R8 binary wrap", cnt_b, 15);
  endtask

  task automatic t_count();
    cnt_clk = 1'b1; wait_cyc(2);
    chk("R2 not yet after two edges", cnt_d, 9);
    wait_cyc(1);
    chk("R2 decrement on third edge", cnt_d, 8);
    cnt_clk = 1'b0; wait_cyc(5);
    chk("R2 falling clock ignored", cnt_d, 8);
    pulse();
    chk("R2 second decrement", cnt_d, 7);
  endtask

  task automatic t_hold();
    hold = 1'b1; wait_cyc(5);
    pulse(); pulse();
    chk("R3 hold blocks count clock", cnt_d, 7);
    cnt_clk = 1'b1; wait_cyc(5);
    chk("R3 rise during hold ignored", cnt_d, 7);
    hold = 1'b0; wait_cyc(5);
    chk("R4 hold fall with clock high", cnt_d, 6);
    cnt_clk = 1'b0; wait_cyc(5);
    hold = 1'b1; wait_cyc(5);
    hold = 1'b0; wait_cyc(5);
    chk("R4 hold fall with clock low ignored", cnt_d, 6);
  endtask

  task automatic t_load();
    preset = 4'd3; load_drv = 1'b1; wait_cyc(5);
    chk("R5 preset loaded", cnt_d, 3);
    pulse();
    chk("R5 load overrides counting", cnt_d, 3);
    load_drv = 1'b0; wait_cyc(5);
    pulse();
    chk("R5 counts after load release", cnt_d, 2);
    do_load(4'd12);
    chk("R9 out-of-range preset kept", cnt_d, 12);
    pulse();
    chk("R9 counts down from 12", cnt_d, 11);
  endtask

  task automatic t_clear();
    preset = 4'd7; load_drv = 1'b1; clear = 1'b1; wait_cyc(5);
    chk("R6 clear beats load", cnt_d, 0);
    chk("R7 zero low during clear", zero_d, 0);
    pulse();
    chk("R6 clear beats counting", cnt_d, 0);
    clear = 1'b0; wait_cyc(5);
    chk("R5 load after clear released", cnt_d, 7);
    load_drv = 1'b0; wait_cyc(2);
    clear = 1'b1; wait_cyc(5);
    clear = 1'b0; wait_cyc(5);
    chk("R6 clear from 7", cnt_d, 0);
  endtask

  task automatic t_zero();
    cf = 1'b0; wait_cyc(2);
    chk("R7 zero gated by chain input", zero_d, 0);
    cf = 1'b1; wait_cyc(2);
    chk("R7 zero flag high at 0", zero_d, 1);
    pulse();
    chk("R7 zero low at nonzero", zero_d, 0);
  endtask

  task automatic t_divide();
    clear = 1'b1; wait_cyc(5); clear = 1'b0;
    preset = 4'd5; fb_mode = 1'b1; wait_cyc(10);
    chk("R10 initial reload", cnt_d, 5);
    count_rises = 1'b1;
    for (int i = 0; i < 15; i++) pulse();
    count_rises = 1'b0;
    chk("R10 divide by five", zero_rises, 3);
    chk("R10 back at preset", cnt_d, 5);
    fb_mode = 1'b0;
  endtask

  initial begin
    t_reset();
    t_wrap();
    t_count();
    t_hold();
    t_load();
    t_clear();
    t_zero();
    t_divide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule